// File: doc/BRIEF.md
# DMA Transfer Length and Status Tracker

This block follows how many bytes remain in the block transfer of one DMA channel and reports when the transfer has finished or could not start. Software loads a 16-bit remaining-byte count and a 32-bit destination address through a small register write port. It then issues a start request together with an access size (byte, word, longword or 16-byte line) and an addressing mode (single or dual address). The bus side of the channel reports each completed address phase with a one-cycle read or write pulse. The tracker subtracts the access size from the count at each counted pulse.

In dual address mode only write address phases are counted, and the destination address moves forward by the access size after each of them, so the next destination is always ready. In single address mode every address phase is counted and the destination address is left alone. A start whose count is not a whole number of accesses is refused and flagged as a configuration error. The done and error flags stay set until software clears them by writing ones to the status register, or until the next start.

All control and status pins are plain levels or single-cycle pulses. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `dma_xfer_tracker`

## Requirements
- R1: After reset, remaining_bytes, dest_addr, busy, done and cfg_err are all zero.
- R2: A register write with reg_wr_sel = 0 loads remaining_bytes from reg_wr_data[15:0], and reg_wr_sel = 1 loads dest_addr from reg_wr_data[31:0]; the new value shows one cycle later. Writes are ignored while busy and in a cycle where start_req is high.
- R3: xfer_size is encoded 00 = longword (step 4), 01 = byte (step 1), 10 = word (step 2), 11 = line (step 16); each counted address phase lowers remaining_bytes by that step.
- R4: With dual_addr = 1, only wr_aphase_done is counted. Each counted phase also raises dest_addr by the step. A read pulse alone changes neither register.
- R5: With dual_addr = 0, a cycle with rd_aphase_done or wr_aphase_done (or both) counts once, and dest_addr does not change.
- R6: At the edge where remaining_bytes reaches zero, busy falls and done is set.
- R7: A start whose count is not a multiple of 16 (line), 4 (longword) or 2 (word) sets cfg_err. busy stays low and remaining_bytes is unchanged.
- R8: An accepted start (start_req while not busy) clears done and cfg_err. A start with a zero count sets done without raising busy. start_req while busy is ignored.
- R9: Address-phase pulses while busy is low leave remaining_bytes and dest_addr unchanged.
- R10: A write with reg_wr_sel = 2 clears done where reg_wr_data[0] = 1 and clears cfg_err where reg_wr_data[1] = 1. Any other bit leaves its flag as it is. Setting a flag at the same edge takes priority over clearing it.
- R11: Size and mode are captured at the accepted start. Changing xfer_size or dual_addr while busy has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 count, 1 destination, 2 status |
| reg_wr_data | input | 32 | Register write data |
| start_req | input | 1 | Start pulse for a block transfer |
| xfer_size | input | 2 | Access size code |
| dual_addr | input | 1 | 1 = dual address mode, 0 = single address mode |
| rd_aphase_done | input | 1 | A read address phase completed |
| wr_aphase_done | input | 1 | A write address phase completed |
| remaining_bytes | output | 16 | Bytes still to transfer |
| dest_addr | output | 32 | Current destination address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky block-complete flag |
| cfg_err | output | 1 | Sticky misaligned-start flag |

## Verification
All results are registered. A write, a start or an address-phase pulse that is sampled at one rising edge is visible on remaining_bytes, dest_addr, busy, done and cfg_err just after that same edge, with no further latency. The bench drives a stimulus for exactly one edge and reads the outputs 1 ns after that edge. It also runs a behavioural model that updates at every edge and is compared with all five outputs 1 ns after each edge. The checker module asserts the same one-edge relations for decrements, destination moves, finishing and idle stability.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_DEST   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int STEP_W = 5;

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: step_of = STEP_W'(1);
      SZ_WORD: step_of = STEP_W'(2);
      SZ_LINE: step_of = STEP_W'(16);
      default: step_of = STEP_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/dma_step_decode.sv
module dma_step_decode
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  count,
  output logic [STEP_W-1:0] step,
  output logic              misaligned,
  output logic              zero
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    step       = step_of(size);
    mask       = CNT_W'(step) - CNT_W'(1);
    misaligned = |(count & mask);
    zero       = (count == '0);
  end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_data,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic              dual_in,
  input  logic              rd_done,
  input  logic              wr_done,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output logic              dual_o,
  output logic              accept_o,
  output logic              dest_adv_o,
  output logic              fin_o,
  output logic              start_err_o,
  output logic              start_zero_o
);
  logic [CNT_W-1:0]  count_q, cnt_next;
  logic              busy_q, dual_q, ev;
  logic [STEP_W-1:0] step_q, dec_step;
  logic              dec_mis, dec_zero;

  dma_step_decode #(.CNT_W(CNT_W)) u_dec (
    .size       (size),
    .count      (count_q),
    .step       (dec_step),
    .misaligned (dec_mis),
    .zero       (dec_zero)
  );

  always_comb begin
    accept_o     = start && !busy_q;
    ev           = busy_q && (dual_q ? wr_done : (rd_done || wr_done));
    cnt_next     = count_q - CNT_W'(step_q);
    fin_o        = ev && (cnt_next == '0);
    dest_adv_o   = ev && dual_q;
    start_err_o  = accept_o && dec_mis;
    start_zero_o = accept_o && !dec_mis && dec_zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      busy_q  <= 1'b0;
      step_q  <= STEP_W'(4);
      dual_q  <= 1'b0;
    end else if (accept_o) begin
      if (!dec_mis && !dec_zero) begin
        busy_q <= 1'b1;
        step_q <= dec_step;
        dual_q <= dual_in;
      end
    end else if (ev) begin
      count_q <= cnt_next;
      if (fin_o) busy_q <= 1'b0;
    end else if (load_en) begin
      count_q <= load_data;
    end
  end

  assign count_o = count_q;
  assign busy_o  = busy_q;
  assign step_o  = step_q;
  assign dual_o  = dual_q;
endmodule

// File: rtl/dma_dest_unit.sv
module dma_dest_unit
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_data,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] dest_o
);
  logic [ADDR_W-1:0] dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       dest_q <= '0;
    else if (adv)     dest_q <= dest_q + ADDR_W'(step);
    else if (load_en) dest_q <= load_data;
  end

  assign dest_o = dest_q;
endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       set_done,
  input  logic       set_err,
  input  logic       clr_en,
  input  logic [1:0] clr_bits,
  output logic       done_o,
  output logic       err_o
);
  logic done_q, err_q, clr_done, clr_err;

  always_comb begin
    clr_done = clr_en && clr_bits[0];
    clr_err  = clr_en && clr_bits[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      done_q <= set_done;
      err_q  <= set_err;
    end else begin
      done_q <= (done_q && !clr_done) || set_done;
      err_q  <= err_q && !clr_err;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              start_req,
  input  logic [1:0]        xfer_size,
  input  logic              dual_addr,
  input  logic              rd_aphase_done,
  input  logic              wr_aphase_done,
  output logic [CNT_W-1:0]  remaining_bytes,
  output logic [ADDR_W-1:0] dest_addr,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  logic              wr_ok, accept, dest_adv, fin, start_err, start_zero, dual_q;
  logic [STEP_W-1:0] step_q;

  assign wr_ok = reg_wr_en && !busy && !start_req;

  dma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_en      (wr_ok && (reg_wr_sel == SEL_COUNT)),
    .load_data    (reg_wr_data[CNT_W-1:0]),
    .start        (start_req),
    .size         (xfer_size),
    .dual_in      (dual_addr),
    .rd_done      (rd_aphase_done),
    .wr_done      (wr_aphase_done),
    .count_o      (remaining_bytes),
    .busy_o       (busy),
    .step_o       (step_q),
    .dual_o       (dual_q),
    .accept_o     (accept),
    .dest_adv_o   (dest_adv),
    .fin_o        (fin),
    .start_err_o  (start_err),
    .start_zero_o (start_zero)
  );

  dma_dest_unit #(.ADDR_W(ADDR_W)) u_dest (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (wr_ok && (reg_wr_sel == SEL_DEST)),
    .load_data (reg_wr_data[ADDR_W-1:0]),
    .adv       (dest_adv),
    .step      (step_q),
    .dest_o    (dest_addr)
  );

  dma_status_unit u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .set_done (fin || start_zero),
    .set_err  (start_err),
    .clr_en   (wr_ok && (reg_wr_sel == SEL_STATUS)),
    .clr_bits (reg_wr_data[1:0]),
    .done_o   (done),
    .err_o    (cfg_err)
  );
endmodule

// File: rtl/dma_xfer_tracker_chk.sv
module dma_xfer_tracker_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic              start_req,
  input logic              rd_aphase_done,
  input logic              wr_aphase_done,
  input logic [CNT_W-1:0]  remaining_bytes,
  input logic [ADDR_W-1:0] dest_addr,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic [4:0]        step_q,
  input logic              dual_q
);
  // R6: busy only falls at the edge that also sets done
  a_r6_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: a refused start never leaves the channel busy
  a_r7_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R3: a running count is a nonzero whole number of steps
  a_r3_count_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((remaining_bytes & (CNT_W'(step_q) - CNT_W'(1))) == '0)
              && (remaining_bytes != '0)));

  // R4: counted write in dual mode moves both count and destination
  a_r4_dual_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dual_q && wr_aphase_done) |=>
      ((remaining_bytes == $past(remaining_bytes) - CNT_W'($past(step_q)))
       && (dest_addr == $past(dest_addr) + ADDR_W'($past(step_q)))));

  // R4: read phase alone is not counted in dual mode
  a_r4_dual_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dual_q && rd_aphase_done && !wr_aphase_done) |=>
      ($stable(remaining_bytes) && $stable(dest_addr)));

  // R5: single mode never moves the destination
  a_r5_single_dest_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dual_q) |=> $stable(dest_addr));

  // R9: idle count only changes through a count write
  a_r9_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(reg_wr_en && (reg_wr_sel == 2'd0))) |=> $stable(remaining_bytes));
endmodule

bind dma_xfer_tracker dma_xfer_tracker_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .reg_wr_en       (reg_wr_en),
  .reg_wr_sel      (reg_wr_sel),
  .start_req       (start_req),
  .rd_aphase_done  (rd_aphase_done),
  .wr_aphase_done  (wr_aphase_done),
  .remaining_bytes (remaining_bytes),
  .dest_addr       (dest_addr),
  .busy            (busy),
  .done            (done),
  .cfg_err         (cfg_err),
  .step_q          (step_q),
  .dual_q          (dual_q)
);

// File: tb/dma_xfer_tracker_tb.sv
`timescale 1ns/1ps
module dma_xfer_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd3;
  logic [31:0] reg_wr_data = '0;
  logic        start_req = 1'b0;
  logic [1:0]  xfer_size = 2'b00;
  logic        dual_addr = 1'b0;
  logic        rd_p = 1'b0, wr_p = 1'b0;
  logic [15:0] remaining_bytes;
  logic [31:0] dest_addr;
  logic        busy, done, cfg_err;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference state
  int unsigned m_cnt = 0, m_dst = 0, m_step = 4;
  bit m_busy = 0, m_done = 0, m_err = 0, m_dual = 0;

  always #2 clk = ~clk;

  dma_xfer_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .start_req(start_req), .xfer_size(xfer_size),
    .dual_addr(dual_addr), .rd_aphase_done(rd_p), .wr_aphase_done(wr_p),
    .remaining_bytes(remaining_bytes), .dest_addr(dest_addr),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  function automatic int unsigned size_bytes(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 2;
    if (s == 2'b11) return 16;
    return 4;
  endfunction

  // model update at each edge from the inputs held across it
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dst = 0; m_busy = 0; m_done = 0; m_err = 0; m_dual = 0; m_step = 4;
    end else begin
      bit st, ev, wok;
      st  = start_req && !m_busy;
      ev  = m_busy && (m_dual ? wr_p : (rd_p || wr_p));
      wok = reg_wr_en && !m_busy && !start_req;
      if (st) begin
        int unsigned s;
        s = size_bytes(xfer_size);
        m_done = 0; m_err = 0;
        if (m_cnt % s != 0) m_err = 1;
        else if (m_cnt == 0) m_done = 1;
        else begin m_busy = 1; m_step = s; m_dual = dual_addr; end
      end else if (ev) begin
        m_cnt = m_cnt - m_step;
        if (m_dual) m_dst = m_dst + m_step;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end else if (wok) begin
        if (reg_wr_sel == 2'd0) m_cnt = reg_wr_data[15:0];
        if (reg_wr_sel == 2'd1) m_dst = reg_wr_data;
        if (reg_wr_sel == 2'd2) begin
          if (reg_wr_data[0]) m_done = 0;
          if (reg_wr_data[1]) m_err = 0;
        end
      end
    end
  end

  // every-cycle comparison 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      total++;
      if (remaining_bytes != m_cnt[15:0] || dest_addr != m_dst || busy != m_busy
          || done != m_done || cfg_err != m_err) begin
        bad++;
        $display("FAIL %s model: cnt=%h/%h dst=%h/%h busy=%0b/%0b done=%0b/%0b err=%0b/%0b",
                 tag, remaining_bytes, m_cnt[15:0], dest_addr, m_dst, busy, m_busy,
                 done, m_done, cfg_err, m_err);
      end
    end
  end

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic step_edge();
    @(posedge clk); #1;
    reg_wr_en = 0; start_req = 0; rd_p = 0; wr_p = 0;
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    step_edge();
  endtask

  task automatic go(input logic [1:0] sz, input logic dual);
    @(negedge clk); start_req = 1; xfer_size = sz; dual_addr = dual;
    step_edge();
  endtask

  task automatic ph(input logic r, input logic w);
    @(negedge clk); rd_p = r; wr_p = w;
    step_edge();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("R1", "count", remaining_bytes, 0);
    chk("R1", "dest", dest_addr, 0);
    chk("R1", "flags", {busy, done, cfg_err}, 0);
    @(negedge clk); rst_n = 1;

    tag = "R2";
    wreg(2'd0, 32'hABCD_0040);
    chk("R2", "count load", remaining_bytes, 16'h0040);
    wreg(2'd1, 32'h1000_0000);
    chk("R2", "dest load", dest_addr, 32'h1000_0000);

    tag = "R4";
    go(2'b00, 1'b1);
    chk("R4", "busy after start", busy, 1);
    ph(1, 0);
    chk("R4", "read ignored count", remaining_bytes, 16'h0040);
    chk("R4", "read ignored dest", dest_addr, 32'h1000_0000);
    ph(0, 1);
    chk("R3", "longword step", remaining_bytes, 16'h003C);
    chk("R4", "dest advance", dest_addr, 32'h1000_0004);
    for (int i = 0; i < 14; i++) ph(0, 1);
    chk("R6", "before last busy", busy, 1);
    tag = "R6";
    ph(0, 1);
    chk("R6", "count zero", remaining_bytes, 0);
    chk("R6", "busy fell", busy, 0);
    chk("R6", "done set", done, 1);
    chk("R4", "final dest", dest_addr, 32'h1000_0040);

    tag = "R10";
    wreg(2'd2, 32'h2);
    chk("R10", "err clear leaves done", done, 1);
    wreg(2'd2, 32'h1);
    chk("R10", "done cleared", done, 0);

    tag = "R7";
    wreg(2'd0, 32'h6);
    go(2'b00, 1'b0);
    chk("R7", "cfg_err", cfg_err, 1);
    chk("R7", "not busy", busy, 0);
    chk("R7", "count kept", remaining_bytes, 6);

    tag = "R8";
    wreg(2'd1, 32'h2000_0000);
    go(2'b01, 1'b0);
    chk("R8", "err cleared by start", cfg_err, 0);
    chk("R8", "busy", busy, 1);
    tag = "R5";
    ph(1, 0);
    chk("R5", "read counts", remaining_bytes, 5);
    ph(0, 1);
    chk("R5", "write counts", remaining_bytes, 4);
    ph(1, 1);
    chk("R5", "both count once", remaining_bytes, 3);
    chk("R5", "dest fixed", dest_addr, 32'h2000_0000);
    tag = "R11";
    @(negedge clk); xfer_size = 2'b11; dual_addr = 1'b1;
    ph(1, 0);
    chk("R11", "size/mode held", remaining_bytes, 2);
    tag = "R2";
    wreg(2'd0, 32'h100);
    chk("R2", "write while busy", remaining_bytes, 2);
    tag = "R8";
    go(2'b11, 1'b1);
    chk("R8", "start while busy", remaining_bytes, 2);
    chk("R8", "no error while busy", cfg_err, 0);
    ph(0, 1); ph(0, 1);
    chk("R6", "byte run done", done, 1);

    tag = "R8";
    go(2'b10, 1'b0);
    chk("R8", "zero start done", done, 1);
    chk("R8", "zero start idle", busy, 0);

    tag = "R9";
    wreg(2'd0, 32'h8);
    ph(1, 1);
    chk("R9", "idle pulse count", remaining_bytes, 8);
    chk("R9", "idle pulse dest", dest_addr, 32'h2000_0000);

    tag = "R7";
    wreg(2'd0, 32'h3);
    go(2'b10, 1'b0);
    chk("R7", "word misaligned", cfg_err, 1);
    tag = "R3";
    wreg(2'd0, 32'h4);
    go(2'b10, 1'b1);
    ph(0, 1);
    chk("R3", "word step", remaining_bytes, 2);
    chk("R3", "word dest", dest_addr, 32'h2000_0002);
    ph(0, 1);
    wreg(2'd0, 32'h20);
    go(2'b11, 1'b0);
    ph(1, 0);
    chk("R3", "line step", remaining_bytes, 16'h10);
    ph(1, 0);
    chk("R6", "line done", done, 1);

    tag = "R10";
    wreg(2'd0, 32'h18);
    go(2'b11, 1'b0);
    chk("R7", "line misaligned", cfg_err, 1);
    wreg(2'd2, 32'h1);
    chk("R10", "done bit leaves err", cfg_err, 1);
    wreg(2'd2, 32'hFFFF_FFFE);
    chk("R10", "err cleared", cfg_err, 0);

    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule